// File: doc/BRIEF.md
# Priority-Based DMA Request Gate

This block sits between the activation sources of the chip's transfer engines and the engines themselves. It lets the CPU hold off bus masters whose priority is below its own. There are three kinds of masters. One is an event-driven transfer controller with a single priority level. Another is an internal DMA controller with `NUM_DMA` channels, each with its own level. The last is an external-bus DMA controller with `NUM_XDMA` (four) channels, each with its own level. Every level is a 3-bit value, and a larger number means a higher priority.

Each requester has a pending flag. A raw request sets the flag. The flag stays set until the downstream controller acknowledges the forwarded request. A requester is held while gating is enabled and the CPU level is strictly greater than the requester's own level. While held, its request is kept in the pending flag and is not forwarded. When gating is disabled, every request passes straight through. The CPU level is a register that software can write. It is also loaded from the accepted interrupt's level when an interrupt is taken, so that exception handling can run ahead of lower-priority transfers.

Top module: `prio_req_gate`

## Requirements
- R1: After reset, gating is disabled and every priority level and pending flag is 0. `cpu_prio_o` reads 0, and every `*_req_o` is 0 while no raw request is present.
- R2: While gating is disabled, each requester's `*_req_o` equals its raw request OR its pending flag, whatever the levels are.
- R3: While gating is enabled and the CPU level is strictly greater than a requester's level, that requester's `*_req_o` is 0.
- R4: While gating is enabled, a requester whose level is equal to or greater than the CPU level forwards its raw request OR its pending flag.
- R5: A held request is kept as pending. It is forwarded in the first cycle in which the hold condition no longer applies, whether the CPU level has dropped or gating has been disabled.
- R6: An acknowledge clears the requester's pending flag at the next clock edge. It wins over a raw request in the same cycle.
- R7: When `ctl_we_i` is 1, the next clock edge loads the gating enable from `ctl_en_i`, the transfer-controller level from `ctl_xfer_prio_i`, and, when no interrupt is accepted in that cycle, the CPU level from `ctl_cpu_prio_i`.
- R8: Each internal DMA channel has its own level. Bit i of `dma_prio_we_i` loads channel i from `dma_prio_wdata_i`, and each channel is gated independently.
- R9: Each of the four external-bus DMA channels has its own level, loaded by bit i of `xdma_prio_we_i` from `xdma_prio_wdata_i`, and each is gated independently.
- R10: When `irq_ack_i` is 1, the next clock edge loads the CPU level from `irq_level_i`. The new value shows on `cpu_prio_o` and takes part in gating from that edge on.
- R11: When an interrupt is accepted and `ctl_we_i` is 1 in the same cycle, the CPU level takes the interrupt level. The enable and the transfer-controller level still take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Write strobe for enable, CPU level and transfer-controller level |
| ctl_en_i | input | 1 | Gating enable write value |
| ctl_cpu_prio_i | input | 3 | CPU level write value |
| ctl_xfer_prio_i | input | 3 | Transfer-controller level write value |
| irq_ack_i | input | 1 | Interrupt accepted this cycle |
| irq_level_i | input | 3 | Level of the accepted interrupt |
| dma_prio_we_i | input | NUM_DMA | Per-channel level write strobe, internal DMA |
| dma_prio_wdata_i | input | 3 | Level write value, internal DMA |
| xdma_prio_we_i | input | NUM_XDMA | Per-channel level write strobe, external-bus DMA |
| xdma_prio_wdata_i | input | 3 | Level write value, external-bus DMA |
| xfer_req_i | input | 1 | Raw request, transfer controller |
| xfer_ack_i | input | 1 | Acknowledge, transfer controller |
| xfer_req_o | output | 1 | Gated request, transfer controller |
| dma_req_i | input | NUM_DMA | Raw requests, internal DMA |
| dma_ack_i | input | NUM_DMA | Acknowledges, internal DMA |
| dma_req_o | output | NUM_DMA | Gated requests, internal DMA |
| xdma_req_i | input | NUM_XDMA | Raw requests, external-bus DMA |
| xdma_ack_i | input | NUM_XDMA | Acknowledges, external-bus DMA |
| xdma_req_o | output | NUM_XDMA | Gated requests, external-bus DMA |
| cpu_prio_o | output | 3 | Current CPU level |

## Verification
The bench directs cases where a requester's level equals the CPU level. A design that compares with greater-or-equal would wrongly hold those requesters. It checks that a held request comes out once the CPU level is lowered. A design that drops held requests would never forward it, and one that forwards a request already acknowledged would keep it on. It drives an interrupt and a software write in the same cycle, which exposes a write port given the wrong precedence or one that drops the enable write. Random traffic with rare acknowledges then mixes level writes per channel. A channel index swapped between the level register and the request would show up as a mismatch on some channel.

// File: rtl/prio_gate_pkg.sv
package prio_gate_pkg;
  localparam int unsigned PRIO_W = 3;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/prio_cpu_ctl.sv
module prio_cpu_ctl
  import prio_gate_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ctl_we_i,
  input  logic  ctl_en_i,
  input  prio_t ctl_cpu_prio_i,
  input  logic  irq_ack_i,
  input  prio_t irq_level_i,
  output logic  en_o,
  output prio_t cpu_prio_o
);
  logic  en_q;
  prio_t cpu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cpu_q <= '0;
    end else begin
      if (ctl_we_i) en_q <= ctl_en_i;
      // interrupt load has precedence over software write
      if (irq_ack_i)     cpu_q <= irq_level_i;
      else if (ctl_we_i) cpu_q <= ctl_cpu_prio_i;
    end
  end

  assign en_o       = en_q;
  assign cpu_prio_o = cpu_q;
endmodule

// File: rtl/prio_req_cell.sv
module prio_req_cell
  import prio_gate_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  gate_en_i,
  input  prio_t cpu_prio_i,
  input  logic  prio_we_i,
  input  prio_t prio_wdata_i,
  input  logic  req_i,
  input  logic  ack_i,
  output logic  req_o,
  output prio_t prio_o,
  output logic  pend_o
);
  prio_t prio_q;
  logic  pend_q;
  logic  hold;
  logic  live;

  assign hold = gate_en_i && (cpu_prio_i > prio_q);
  assign live = req_i | pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (prio_we_i) prio_q <= prio_wdata_i;
      pend_q <= live & ~ack_i;
    end
  end

  assign req_o  = live & ~hold;
  assign prio_o = prio_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/prio_req_gate.sv
module prio_req_gate
  import prio_gate_pkg::*;
#(
  parameter int unsigned NUM_DMA  = 4,
  parameter int unsigned NUM_XDMA = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctl_we_i,
  input  logic                ctl_en_i,
  input  logic [PRIO_W-1:0]   ctl_cpu_prio_i,
  input  logic [PRIO_W-1:0]   ctl_xfer_prio_i,
  input  logic                irq_ack_i,
  input  logic [PRIO_W-1:0]   irq_level_i,
  input  logic [NUM_DMA-1:0]  dma_prio_we_i,
  input  logic [PRIO_W-1:0]   dma_prio_wdata_i,
  input  logic [NUM_XDMA-1:0] xdma_prio_we_i,
  input  logic [PRIO_W-1:0]   xdma_prio_wdata_i,
  input  logic                xfer_req_i,
  input  logic                xfer_ack_i,
  output logic                xfer_req_o,
  input  logic [NUM_DMA-1:0]  dma_req_i,
  input  logic [NUM_DMA-1:0]  dma_ack_i,
  output logic [NUM_DMA-1:0]  dma_req_o,
  input  logic [NUM_XDMA-1:0] xdma_req_i,
  input  logic [NUM_XDMA-1:0] xdma_ack_i,
  output logic [NUM_XDMA-1:0] xdma_req_o,
  output logic [PRIO_W-1:0]   cpu_prio_o
);
  logic  gate_en;
  prio_t cpu_prio;
  prio_t xfer_prio;
  logic  xfer_pend;
  logic [NUM_DMA-1:0][PRIO_W-1:0]  dma_prio;
  logic [NUM_DMA-1:0]              dma_pend;
  logic [NUM_XDMA-1:0][PRIO_W-1:0] xdma_prio;
  logic [NUM_XDMA-1:0]             xdma_pend;

  prio_cpu_ctl u_ctl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctl_we_i       (ctl_we_i),
    .ctl_en_i       (ctl_en_i),
    .ctl_cpu_prio_i (ctl_cpu_prio_i),
    .irq_ack_i      (irq_ack_i),
    .irq_level_i    (irq_level_i),
    .en_o           (gate_en),
    .cpu_prio_o     (cpu_prio)
  );

  prio_req_cell u_xfer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gate_en_i    (gate_en),
    .cpu_prio_i   (cpu_prio),
    .prio_we_i    (ctl_we_i),
    .prio_wdata_i (ctl_xfer_prio_i),
    .req_i        (xfer_req_i),
    .ack_i        (xfer_ack_i),
    .req_o        (xfer_req_o),
    .prio_o       (xfer_prio),
    .pend_o       (xfer_pend)
  );

  for (genvar i = 0; i < NUM_DMA; i++) begin : g_dma
    prio_req_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .gate_en_i    (gate_en),
      .cpu_prio_i   (cpu_prio),
      .prio_we_i    (dma_prio_we_i[i]),
      .prio_wdata_i (dma_prio_wdata_i),
      .req_i        (dma_req_i[i]),
      .ack_i        (dma_ack_i[i]),
      .req_o        (dma_req_o[i]),
      .prio_o       (dma_prio[i]),
      .pend_o       (dma_pend[i])
    );
  end

  for (genvar i = 0; i < NUM_XDMA; i++) begin : g_xdma
    prio_req_cell u_cell (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .gate_en_i    (gate_en),
      .cpu_prio_i   (cpu_prio),
      .prio_we_i    (xdma_prio_we_i[i]),
      .prio_wdata_i (xdma_prio_wdata_i),
      .req_i        (xdma_req_i[i]),
      .ack_i        (xdma_ack_i[i]),
      .req_o        (xdma_req_o[i]),
      .prio_o       (xdma_prio[i]),
      .pend_o       (xdma_pend[i])
    );
  end

  assign cpu_prio_o = cpu_prio;
endmodule

// File: rtl/prio_req_gate_chk.sv
module prio_req_gate_chk #(
  parameter int unsigned PW       = 3,
  parameter int unsigned NUM_DMA  = 4,
  parameter int unsigned NUM_XDMA = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         ctl_we_i,
  input logic                         ctl_en_i,
  input logic [PW-1:0]                ctl_cpu_prio_i,
  input logic                         irq_ack_i,
  input logic [PW-1:0]                irq_level_i,
  input logic                         gate_en,
  input logic [PW-1:0]                cpu_prio_o,
  input logic [PW-1:0]                xfer_prio,
  input logic                         xfer_req_o,
  input logic [NUM_DMA-1:0][PW-1:0]   dma_prio,
  input logic [NUM_DMA-1:0]           dma_pend,
  input logic [NUM_DMA-1:0]           dma_req_i,
  input logic [NUM_DMA-1:0]           dma_ack_i,
  input logic [NUM_DMA-1:0]           dma_req_o,
  input logic [NUM_XDMA-1:0][PW-1:0]  xdma_prio,
  input logic [NUM_XDMA-1:0]          xdma_req_o
);
  assert_sw_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && !irq_ack_i |=> cpu_prio_o == $past(ctl_cpu_prio_i) && gate_en == $past(ctl_en_i));

  assert_irq_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i |=> cpu_prio_o == $past(irq_level_i));

  assert_irq_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_i && ctl_we_i |=> cpu_prio_o == $past(irq_level_i) && gate_en == $past(ctl_en_i));

  assert_xfer_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en && (cpu_prio_o > xfer_prio) |-> !xfer_req_o);

  for (genvar i = 0; i < NUM_DMA; i++) begin : g_dma_chk
    assert_dma_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_en && (cpu_prio_o > dma_prio[i]) |-> !dma_req_o[i]);
    assert_dma_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gate_en |-> dma_req_o[i] == (dma_req_i[i] | dma_pend[i]));
    assert_dma_fwd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_en && (cpu_prio_o <= dma_prio[i]) |-> dma_req_o[i] == (dma_req_i[i] | dma_pend[i]));
    assert_dma_retain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_pend[i] && !dma_ack_i[i] |=> dma_pend[i]);
    assert_dma_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_ack_i[i] |=> !dma_pend[i]);
  end

  for (genvar i = 0; i < NUM_XDMA; i++) begin : g_xdma_chk
    assert_xdma_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_en && (cpu_prio_o > xdma_prio[i]) |-> !xdma_req_o[i]);
  end
endmodule

bind prio_req_gate prio_req_gate_chk #(
  .PW       (prio_gate_pkg::PRIO_W),
  .NUM_DMA  (NUM_DMA),
  .NUM_XDMA (NUM_XDMA)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ctl_we_i       (ctl_we_i),
  .ctl_en_i       (ctl_en_i),
  .ctl_cpu_prio_i (ctl_cpu_prio_i),
  .irq_ack_i      (irq_ack_i),
  .irq_level_i    (irq_level_i),
  .gate_en        (gate_en),
  .cpu_prio_o     (cpu_prio_o),
  .xfer_prio      (xfer_prio),
  .xfer_req_o     (xfer_req_o),
  .dma_prio       (dma_prio),
  .dma_pend       (dma_pend),
  .dma_req_i      (dma_req_i),
  .dma_ack_i      (dma_ack_i),
  .dma_req_o      (dma_req_o),
  .xdma_prio      (xdma_prio),
  .xdma_req_o     (xdma_req_o)
);

// File: tb/prio_req_gate_bench.sv
`timescale 1ns/1ps
module prio_req_gate_bench;
  localparam int ND = 4;
  localparam int NX = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic          ctl_we, ctl_en, irq_ack;
  logic [2:0]    ctl_cpu, ctl_xp, irq_lvl, dma_wd, xdma_wd;
  logic [ND-1:0] dma_we, dma_req, dma_ack, dma_out;
  logic [NX-1:0] xdma_we, xdma_req, xdma_ack, xdma_out;
  logic          xfer_req, xfer_ack, xfer_out;
  logic [2:0]    cpu_out;

  prio_req_gate #(.NUM_DMA(ND), .NUM_XDMA(NX)) u_prio_req_gate (
    .clk_i(clk), .rst_ni(rst_ni),
    .ctl_we_i(ctl_we), .ctl_en_i(ctl_en), .ctl_cpu_prio_i(ctl_cpu), .ctl_xfer_prio_i(ctl_xp),
    .irq_ack_i(irq_ack), .irq_level_i(irq_lvl),
    .dma_prio_we_i(dma_we), .dma_prio_wdata_i(dma_wd),
    .xdma_prio_we_i(xdma_we), .xdma_prio_wdata_i(xdma_wd),
    .xfer_req_i(xfer_req), .xfer_ack_i(xfer_ack), .xfer_req_o(xfer_out),
    .dma_req_i(dma_req), .dma_ack_i(dma_ack), .dma_req_o(dma_out),
    .xdma_req_i(xdma_req), .xdma_ack_i(xdma_ack), .xdma_req_o(xdma_out),
    .cpu_prio_o(cpu_out)
  );

  // reference model state
  logic          m_en;
  logic [2:0]    m_cpu, m_xp;
  logic [2:0]    m_dp [ND];
  logic [2:0]    m_xdp[NX];
  logic          m_xpend;
  logic [ND-1:0] m_dpend;
  logic [NX-1:0] m_xdpend;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag;

  function automatic logic gate(logic req, logic pend, logic [2:0] p);
    return (req | pend) & ~(m_en && (m_cpu > p));
  endfunction

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    ctl_we = 0; ctl_en = 0; ctl_cpu = 0; ctl_xp = 0; irq_ack = 0; irq_lvl = 0;
    dma_we = 0; dma_wd = 0; xdma_we = 0; xdma_wd = 0;
    xfer_req = 0; xfer_ack = 0; dma_req = 0; dma_ack = 0; xdma_req = 0; xdma_ack = 0;
  endtask

  // inputs are set at a falling edge; compare, then advance model at the rising edge
  task automatic step();
    logic [ND-1:0] ed;
    logic [NX-1:0] ex;
    #2;
    for (int i = 0; i < ND; i++) ed[i] = gate(dma_req[i], m_dpend[i], m_dp[i]);
    for (int i = 0; i < NX; i++) ex[i] = gate(xdma_req[i], m_xdpend[i], m_xdp[i]);
    chk("cpu_prio", 8'(cpu_out), 8'(m_cpu));
    chk("xfer_req_o", 8'(xfer_out), 8'(gate(xfer_req, m_xpend, m_xp)));
    chk("dma_req_o", 8'(dma_out), 8'(ed));
    chk("xdma_req_o", 8'(xdma_out), 8'(ex));
    @(posedge clk);
    m_xpend  = (xfer_req | m_xpend) & ~xfer_ack;
    m_dpend  = (dma_req | m_dpend) & ~dma_ack;
    m_xdpend = (xdma_req | m_xdpend) & ~xdma_ack;
    if (ctl_we) begin m_en = ctl_en; m_xp = ctl_xp; end
    if (irq_ack) m_cpu = irq_lvl;
    else if (ctl_we) m_cpu = ctl_cpu;
    for (int i = 0; i < ND; i++) if (dma_we[i]) m_dp[i] = dma_wd;
    for (int i = 0; i < NX; i++) if (xdma_we[i]) m_xdp[i] = xdma_wd;
    @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    m_en = 0; m_cpu = 0; m_xp = 0; m_xpend = 0; m_dpend = 0; m_xdpend = 0;
    for (int i = 0; i < ND; i++) m_dp[i] = 0;
    for (int i = 0; i < NX; i++) m_xdp[i] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    tag = "R1 reset"; step();

    // R2: gating off, levels programmed low, CPU level high
    tag = "R2 setup";
    dma_we = '1; dma_wd = 3'd1; xdma_we = '1; xdma_wd = 3'd0;
    ctl_we = 1; ctl_en = 0; ctl_cpu = 3'd7; ctl_xp = 3'd0; step(); idle();
    tag = "R2 passthru"; dma_req = 4'b1010; xdma_req = 4'b0101; xfer_req = 1; step(); idle();
    tag = "R2 pending"; step();
    tag = "R6 ack"; dma_ack = '1; xdma_ack = '1; xfer_ack = 1; step(); idle();
    tag = "R6 cleared"; step();

    // R8 R9: per-channel levels around CPU level 5
    tag = "R8 R9 levels";
    dma_we = 4'b0001; dma_wd = 3'd6; step(); idle();
    dma_we = 4'b0010; dma_wd = 3'd5; step(); idle();
    dma_we = 4'b0100; dma_wd = 3'd4; step(); idle();
    dma_we = 4'b1000; dma_wd = 3'd0; step(); idle();
    xdma_we = 4'b0011; xdma_wd = 3'd5; step(); idle();
    xdma_we = 4'b1100; xdma_wd = 3'd2; step(); idle();
    tag = "R7 enable"; ctl_we = 1; ctl_en = 1; ctl_cpu = 3'd5; ctl_xp = 3'd3; step(); idle();
    tag = "R3 R4 gate"; dma_req = '1; xdma_req = '1; xfer_req = 1; step(); idle();
    tag = "R3 held"; step();
    tag = "R5 release"; ctl_we = 1; ctl_en = 1; ctl_cpu = 3'd2; ctl_xp = 3'd3; step(); idle();
    tag = "R5 forwarded"; step();
    tag = "R10 irq"; irq_ack = 1; irq_lvl = 3'd7; step(); idle();
    tag = "R10 gated"; step();
    tag = "R11 collide"; irq_ack = 1; irq_lvl = 3'd4; ctl_we = 1; ctl_en = 0; ctl_cpu = 3'd1; ctl_xp = 3'd6;
    step(); idle();
    tag = "R11 after"; step();
    tag = "R5 enable off"; ctl_we = 1; ctl_en = 1; ctl_cpu = 3'd7; ctl_xp = 3'd0; step(); idle();
    tag = "R5 enable off2"; ctl_we = 1; ctl_en = 0; ctl_cpu = 3'd7; step(); idle();
    tag = "R6 drain"; dma_ack = '1; xdma_ack = '1; xfer_ack = 1; dma_req = '1; step(); idle();
    step();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      tag = m_en ? "R3 R4 R5 R6 rand" : "R2 R6 rand";
      ctl_we   = ($urandom % 16) == 0;
      ctl_en   = ($urandom % 4) != 0;
      ctl_cpu  = 3'($urandom);
      ctl_xp   = 3'($urandom);
      irq_ack  = ($urandom % 20) == 0;
      irq_lvl  = 3'($urandom);
      dma_we   = (($urandom % 8) == 0) ? 4'($urandom) : '0;
      dma_wd   = 3'($urandom);
      xdma_we  = (($urandom % 8) == 0) ? 4'($urandom) : '0;
      xdma_wd  = 3'($urandom);
      xfer_req = ($urandom % 5) == 0;
      dma_req  = 4'($urandom) & 4'($urandom);
      xdma_req = 4'($urandom) & 4'($urandom);
      xfer_ack = ($urandom % 6) == 0;
      dma_ack  = 4'($urandom) & 4'($urandom) & 4'($urandom);
      xdma_ack = 4'($urandom) & 4'($urandom) & 4'($urandom);
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule